// File: doc/BRIEF.md
# Hybrid Stack-Register Execution Unit

An in-order execution unit that keeps long-lived values in a general register file and short-lived temporaries on a small operand stack. Each cycle it fetches one 32-bit instruction from an external program array at `pc_o`. Instructions move values between registers and the stack, apply an operation to the stack top, load halfwords using the stack top as an index, store halfwords, compare values and branch. Data memory is one synchronous halfword port. A load's read data arrives one cycle after its request.

The unit counts the instructions that empty the stack. Each retired instruction is reported with a section number. The number steps by one after every instruction that leaves the stack empty. A later scheduler can therefore treat each section as independent of the others.

The stack is bounded and never spills to memory. Pushing onto a full stack, or consuming more entries than are present, raises a fault. The unit then freezes until reset.

Top module: `hsx_unit`

## Requirements
- R1: While and after reset (asynchronous, active low), `stk_depth` is 0, `ret_valid`, `ovf_fault`, `unf_fault`, `mem_re` and `mem_we` are 0, `pc_o` is 0 and the section number is 0. Reset also clears faults left by an earlier run.
- R2: Instruction fields are: opcode [31:28], register [27:24], source select [23:22], operation [21:19] and immediate [18:0]. The immediate is zero-extended. Opcode 9 pushes the immediate. Opcode 1 pushes the named register. Opcode 2 pops the top into the named register. Opcode 0 does nothing. Registers reset to 0.
- R3: Opcode 3 with source 0 (immediate) or source 1 (register) replaces the top with `top OP operand`. Operations are 0 add, 1 subtract, 2 and, 3 logical right shift, 4 arithmetic right shift and 5 multiply (low bits). Shift amounts use the operand's low bits.
- R4: Opcode 3 with source 2 consumes the top and the entry below it and pushes `below OP top`, so depth falls by one.
- R5: Opcode 4 pushes a copy of the top.
- R6: Opcode 5 asserts `mem_re` with address `reg + 2*top` and replaces the top with the zero-extended halfword read. It retires two cycles after the previous instruction, where other instructions retire one cycle apart.
- R7: Opcode 6 asserts `mem_we` with address `reg` and data `top[15:0]`, and pops the top.
- R8: Opcode 7 pops the top and records whether it was unsigned-less-than the named register. Opcode 8 sets the next PC to `imm` when that record is true; otherwise execution falls through. Equal values do not branch.
- R9: `ret_sec` carries the section number held when the instruction executed. The number increments by exactly one after each instruction that takes depth from nonzero to zero. Instructions executed at depth zero that leave depth zero do not advance it.
- R10: The stack holds 16 entries. A push (opcodes 1, 4, 9) at depth 16 does not retire, sets `ovf_fault`, and freezes the unit with depth 16.
- R11: An instruction needing one entry (opcodes 2, 3 with source 0 or 1, 5, 6, 7) at depth 0, or opcode 3 with source 2 at depth below 2, does not retire. It sets `unf_fault` and freezes the unit with depth unchanged.
- R12: `ret_valid` pulses for one cycle per retired instruction, one cycle after the edge that completed it, with `ret_pc` giving its address. Depth changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 8 | Address of the instruction being fetched |
| insn_i | input | 32 | Instruction at `pc_o` |
| mem_re | output | 1 | Halfword read request |
| mem_we | output | 1 | Halfword write request |
| mem_addr | output | 16 | Byte address for the read or write |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_re` |
| ret_valid | output | 1 | An instruction retired |
| ret_pc | output | 8 | Address of the retired instruction |
| ret_sec | output | 8 | Section number of the retired instruction |
| stk_depth | output | 5 | Current operand stack depth |
| ovf_fault | output | 1 | Sticky stack overflow fault |
| unf_fault | output | 1 | Sticky stack underflow fault |

## Verification
A store reaches memory on the same edge that executes it. The retire report of a single-cycle instruction appears one cycle after that edge. A load's report appears one cycle later again, after its read data has come back. The bench samples every output on the falling edge. It logs each retire report together with the cycle it appeared in, and it checks memory, depth and faults only after each program has run well past its last instruction. The load timing is checked as a difference between logged retire cycles, so no check depends on a fixed absolute cycle.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

  typedef enum logic [3:0] {
    OPC_NOP   = 4'd0,
    OPC_PUSHR = 4'd1,
    OPC_POPR  = 4'd2,
    OPC_ALU   = 4'd3,
    OPC_DUP   = 4'd4,
    OPC_LDX   = 4'd5,
    OPC_STH   = 4'd6,
    OPC_CMP   = 4'd7,
    OPC_BLT   = 4'd8,
    OPC_PUSHI = 4'd9
  } opc_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_REG = 2'd1,
    SRC_STK = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    AOP_ADD = 3'd0,
    AOP_SUB = 3'd1,
    AOP_AND = 3'd2,
    AOP_SHR = 3'd3,
    AOP_SAR = 3'd4,
    AOP_MUL = 3'd5
  } aop_e;

  typedef struct packed {
    logic [3:0]  opc;
    logic [3:0]  rsel;
    logic [1:0]  src;
    logic [2:0]  aop;
    logic [18:0] imm;
  } insn_t;

endpackage

// File: rtl/hsx_alu.sv
module hsx_alu #(
  parameter int DW = 32
) (
  input  hsx_pkg::aop_e    op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [DW-1:0]    y
);
  import hsx_pkg::*;
  localparam int SHW = $clog2(DW);

  always_comb begin
    case (op)
      AOP_ADD: y = a + b;
      AOP_SUB: y = a - b;
      AOP_AND: y = a & b;
      AOP_SHR: y = a >> b[SHW-1:0];
      AOP_SAR: y = DW'($signed(a) >>> b[SHW-1:0]);
      AOP_MUL: y = a * b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/hsx_stack.sv
module hsx_stack #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          dep_en,
  input  logic [CW-1:0] dep_nxt,
  output logic [CW-1:0] depth,
  output logic [DW-1:0] top,
  output logic [DW-1:0] below
);
  logic [DW-1:0] ent_q [DEPTH];
  logic [CW-1:0] dep_q;
  logic [IW-1:0] top_idx, below_idx;

  assign top_idx   = dep_q[IW-1:0] - IW'(1);
  assign below_idx = dep_q[IW-1:0] - IW'(2);
  assign top       = ent_q[top_idx];
  assign below     = ent_q[below_idx];
  assign depth     = dep_q;

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dep_q <= '0;
    else if (dep_en) dep_q <= dep_nxt;
  end
endmodule

// File: rtl/hsx_regs.sv
module hsx_regs #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] r_q [NREG];

  assign rdata = r_q[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) r_q[i] <= '0;
    end else if (we) begin
      r_q[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/hsx_section.sv
module hsx_section #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [SW-1:0] sec
);
  logic [SW-1:0] sec_q;
  assign sec = sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sec_q <= '0;
    else if (adv) sec_q <= sec_q + SW'(1);
  end
endmodule

// File: rtl/hsx_unit.sv
module hsx_unit #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int NREG  = 16,
  parameter int PW    = 8,
  parameter int AW    = 16,
  parameter int SW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pc_o,
  input  logic [31:0]   insn_i,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          ret_valid,
  output logic [PW-1:0] ret_pc,
  output logic [SW-1:0] ret_sec,
  output logic [CW-1:0] stk_depth,
  output logic          ovf_fault,
  output logic          unf_fault
);
  import hsx_pkg::*;

  insn_t ins;
  opc_e  opc;
  assign ins = insn_t'(insn_i);
  assign opc = opc_e'(ins.opc);

  logic [PW-1:0] pc_q, pc_nxt;
  logic          ldw_q, ldw_nxt;
  logic          lt_q, lt_nxt, lt_en;
  logic          ovf_q, unf_q, set_ovf, set_unf, halted;
  logic          retire;
  logic          rv_q;
  logic [PW-1:0] rpc_q;
  logic [SW-1:0] rsec_q;

  logic          st_wr;
  logic [IW-1:0] st_idx;
  logic [DW-1:0] st_wd;
  logic          dep_en;
  logic [CW-1:0] depth, dep_nxt;
  logic [DW-1:0] top, below;

  logic          rf_we;
  logic [DW-1:0] rval;

  logic [DW-1:0] alu_a, alu_b, alu_y;
  logic [SW-1:0] sec_w;
  logic          sec_adv;

  logic is_push, need_one, need_two, stk_src;
  logic [DW-1:0] imm_x;

  assign imm_x    = DW'(ins.imm);
  assign stk_src  = (src_e'(ins.src) == SRC_STK);
  assign is_push  = (opc == OPC_PUSHR) || (opc == OPC_DUP) || (opc == OPC_PUSHI);
  assign need_two = (opc == OPC_ALU) && stk_src;
  assign need_one = (opc == OPC_POPR) || (opc == OPC_LDX) || (opc == OPC_STH) ||
                    (opc == OPC_CMP) || ((opc == OPC_ALU) && !stk_src);
  assign halted   = ovf_q | unf_q;

  hsx_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr), .wr_idx(st_idx), .wr_data(st_wd),
    .dep_en(dep_en), .dep_nxt(dep_nxt), .depth(depth), .top(top), .below(below)
  );

  hsx_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(ins.rsel[RW-1:0]), .wdata(top),
    .raddr(ins.rsel[RW-1:0]), .rdata(rval)
  );

  hsx_alu #(.DW(DW)) u_alu (
    .op(aop_e'(ins.aop)), .a(alu_a), .b(alu_b), .y(alu_y)
  );

  hsx_section #(.SW(SW)) u_sec (
    .clk(clk), .rst_n(rst_n), .adv(sec_adv), .sec(sec_w)
  );

  // operand selection for the ALU
  always_comb begin
    if (stk_src) begin
      alu_a = below;
      alu_b = top;
    end else begin
      alu_a = top;
      alu_b = (src_e'(ins.src) == SRC_REG) ? rval : imm_x;
    end
  end

  // next-state / control
  always_comb begin
    retire    = 1'b0;
    set_ovf   = 1'b0;
    set_unf   = 1'b0;
    st_wr     = 1'b0;
    st_idx    = depth[IW-1:0] - IW'(1);
    st_wd     = top;
    dep_en    = 1'b0;
    dep_nxt   = depth;
    rf_we     = 1'b0;
    lt_en     = 1'b0;
    lt_nxt    = lt_q;
    ldw_nxt   = 1'b0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = AW'(rval);
    mem_wdata = top[15:0];
    pc_nxt    = pc_q + PW'(1);
    if (!halted) begin
      if (ldw_q) begin
        st_wr  = 1'b1;
        st_wd  = DW'(mem_rdata);
        retire = 1'b1;
      end else if (is_push && (depth == CW'(DEPTH))) begin
        set_ovf = 1'b1;
      end else if ((need_one && (depth == '0)) || (need_two && (depth < CW'(2)))) begin
        set_unf = 1'b1;
      end else begin
        case (opc)
          OPC_PUSHR, OPC_PUSHI, OPC_DUP: begin
            st_wr   = 1'b1;
            st_idx  = depth[IW-1:0];
            st_wd   = (opc == OPC_PUSHR) ? rval : (opc == OPC_PUSHI) ? imm_x : top;
            dep_en  = 1'b1;
            dep_nxt = depth + CW'(1);
            retire  = 1'b1;
          end
          OPC_POPR: begin
            rf_we   = 1'b1;
            dep_en  = 1'b1;
            dep_nxt = depth - CW'(1);
            retire  = 1'b1;
          end
          OPC_ALU: begin
            st_wr  = 1'b1;
            st_wd  = alu_y;
            retire = 1'b1;
            if (stk_src) begin
              st_idx  = depth[IW-1:0] - IW'(2);
              dep_en  = 1'b1;
              dep_nxt = depth - CW'(1);
            end
          end
          OPC_LDX: begin
            mem_re   = 1'b1;
            mem_addr = AW'(rval) + AW'({top, 1'b0});
            ldw_nxt  = 1'b1;
          end
          OPC_STH: begin
            mem_we  = 1'b1;
            dep_en  = 1'b1;
            dep_nxt = depth - CW'(1);
            retire  = 1'b1;
          end
          OPC_CMP: begin
            lt_en   = 1'b1;
            lt_nxt  = top < rval;
            dep_en  = 1'b1;
            dep_nxt = depth - CW'(1);
            retire  = 1'b1;
          end
          OPC_BLT: begin
            if (lt_q) pc_nxt = ins.imm[PW-1:0];
            retire = 1'b1;
          end
          default: retire = 1'b1;
        endcase
      end
    end
    sec_adv = retire && (dep_nxt == '0) && (depth != '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ldw_q  <= 1'b0;
      lt_q   <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      rv_q   <= 1'b0;
      rpc_q  <= '0;
      rsec_q <= '0;
    end else begin
      if (retire)  pc_q  <= pc_nxt;
      if (!halted) ldw_q <= ldw_nxt;
      if (lt_en)   lt_q  <= lt_nxt;
      if (set_ovf) ovf_q <= 1'b1;
      if (set_unf) unf_q <= 1'b1;
      rv_q <= retire;
      if (retire) begin
        rpc_q  <= pc_q;
        rsec_q <= sec_w;
      end
    end
  end

  assign pc_o      = pc_q;
  assign ret_valid = rv_q;
  assign ret_pc    = rpc_q;
  assign ret_sec   = rsec_q;
  assign stk_depth = depth;
  assign ovf_fault = ovf_q;
  assign unf_fault = unf_q;
endmodule

// File: rtl/hsx_chk.sv
module hsx_chk #(
  parameter int DEPTH = 16,
  parameter int SW    = 8,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] depth,
  input logic [SW-1:0] sec,
  input logic          ret_valid,
  input logic          mem_re,
  input logic          mem_we,
  input logic          ovf,
  input logic          unf
);
  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  p_depth_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(depth) |-> (depth == $past(depth) + CW'(1)) || (depth == $past(depth) - CW'(1)));

  p_sec_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec) |-> sec == $past(sec) + SW'(1));

  p_sec_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec) |-> depth == '0);

  p_ovf_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> depth == CW'(DEPTH));

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |=> (ovf || unf));

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |=> (!ret_valid && !mem_re && !mem_we));

  p_mem_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

bind hsx_unit hsx_chk #(.DEPTH(DEPTH), .SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .depth(stk_depth), .sec(sec_w), .ret_valid(ret_valid),
  .mem_re(mem_re), .mem_we(mem_we), .ovf(ovf_fault), .unf(unf_fault)
);

// File: tb/sim_hsx_unit.sv
module sim_hsx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pc_o;
  logic [31:0] insn_i;
  logic        mem_re, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        ret_valid;
  logic [7:0]  ret_pc, ret_sec;
  logic [4:0]  stk_depth;
  logic        ovf_fault, unf_fault;

  logic [31:0] prog [256];
  logic [15:0] dmem [256];
  int np, rc, cyc, nchk, nerr;
  int rsec [64];
  int rpc  [64];
  int rcyc [64];

  always #10 clk = ~clk;

  assign insn_i = prog[pc_o];

  hsx_unit u0 (
    .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .insn_i(insn_i), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_sec(ret_sec), .stk_depth(stk_depth),
    .ovf_fault(ovf_fault), .unf_fault(unf_fault)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) dmem[mem_addr[8:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= dmem[mem_addr[8:1]];
  end

  always @(negedge clk) begin
    if (rst_n && ret_valid && rc < 64) begin
      rsec[rc] = int'(ret_sec);
      rpc[rc]  = int'(ret_pc);
      rcyc[rc] = cyc;
      rc = rc + 1;
    end
  end

  function automatic logic [31:0] enc(int op, int r, int s, int a, int imm);
    return {op[3:0], r[3:0], s[1:0], a[2:0], imm[18:0]};
  endfunction

  task automatic put(logic [31:0] w);
    prog[np] = w;
    np = np + 1;
  endtask

  task automatic fresh();
    for (int i = 0; i < 256; i++) begin
      prog[i] = 32'h0;
      dmem[i] = 16'h0;
    end
    np = 0;
  endtask

  task automatic start(int ncyc);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rc = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
  endtask

  // R4 R3: stack-form subtract uses below - top
  task automatic t_stack_alu();
    fresh();
    put(enc(9,0,0,0,'h20)); put(enc(2,1,0,0,0));
    put(enc(9,0,0,0,100));  put(enc(9,0,0,0,7));
    put(enc(3,0,2,1,0));    put(enc(6,1,0,0,0));
    start(20);
    expect_eq("R4 stack sub result", {16'h0, dmem['h20>>1]}, 32'd93);
    expect_eq("R4 depth back to zero", {27'h0, stk_depth}, 32'd0);
  endtask

  // R3 R2: immediate and register operand forms, push register
  task automatic t_imm_reg();
    fresh();
    put(enc(9,0,0,0,'h22)); put(enc(2,1,0,0,0));
    put(enc(9,0,0,0,5));    put(enc(2,2,0,0,0));
    put(enc(9,0,0,0,'h0F0F));
    put(enc(3,0,0,2,'hFF)); put(enc(3,2,1,0,0));
    put(enc(3,0,0,5,3));    put(enc(3,0,0,3,2));
    put(enc(6,1,0,0,0));
    put(enc(9,0,0,0,'h24)); put(enc(2,1,0,0,0));
    put(enc(9,0,0,0,0));    put(enc(3,0,0,1,16));
    put(enc(3,0,0,4,2));    put(enc(3,0,0,3,26));
    put(enc(6,1,0,0,0));
    put(enc(9,0,0,0,'h26)); put(enc(2,1,0,0,0));
    put(enc(1,2,0,0,0));    put(enc(6,1,0,0,0));
    start(40);
    expect_eq("R3 and/add/mul/shr chain", {16'h0, dmem['h22>>1]}, 32'h000F);
    expect_eq("R3 sub/sar/shr chain", {16'h0, dmem['h24>>1]}, 32'h003F);
    expect_eq("R2 push register", {16'h0, dmem['h26>>1]}, 32'd5);
  endtask

  // R6 R5 R7 R12: indexed load, duplicate, store, load timing
  task automatic t_load();
    fresh();
    dmem['h46>>1] = 16'h8003;
    put(enc(9,0,0,0,'h50)); put(enc(2,1,0,0,0));
    put(enc(9,0,0,0,'h52)); put(enc(2,4,0,0,0));
    put(enc(9,0,0,0,'h40)); put(enc(2,3,0,0,0));
    put(enc(9,0,0,0,3));    put(enc(5,3,0,0,0));
    put(enc(4,0,0,0,0));    put(enc(6,4,0,0,0));
    put(enc(4,0,0,0,0));    put(enc(3,0,2,0,0));
    put(enc(3,0,0,3,16));   put(enc(6,1,0,0,0));
    start(30);
    expect_eq("R6 indexed load value", {16'h0, dmem['h52>>1]}, 32'h8003);
    expect_eq("R5 R6 dup sum zero-extended", {16'h0, dmem['h50>>1]}, 32'd1);
    expect_eq("R6 load retires two cycles later", 32'(rcyc[7] - rcyc[6]), 32'd2);
    expect_eq("R12 next retires one cycle later", 32'(rcyc[8] - rcyc[7]), 32'd1);
    expect_eq("R12 retire pc of load", 32'(rpc[7]), 32'd7);
    expect_eq("R7 store pops to empty", {27'h0, stk_depth}, 32'd0);
  endtask

  // R8: taken when lower, not taken when equal
  task automatic t_branch();
    fresh();
    put(enc(9,0,0,0,'h60)); put(enc(2,1,0,0,0));
    put(enc(9,0,0,0,'h62)); put(enc(2,2,0,0,0));
    put(enc(9,0,0,0,10));   put(enc(2,7,0,0,0));
    put(enc(9,0,0,0,3));    put(enc(7,7,0,0,0));
    put(enc(8,0,0,0,11));
    put(enc(9,0,0,0,'hBAD)); put(enc(6,1,0,0,0));
    put(enc(9,0,0,0,10));   put(enc(7,7,0,0,0));
    put(enc(8,0,0,0,16));
    put(enc(9,0,0,0,'h77)); put(enc(6,2,0,0,0));
    start(30);
    expect_eq("R8 lower branches over store", {16'h0, dmem['h60>>1]}, 32'h0);
    expect_eq("R8 equal falls through", {16'h0, dmem['h62>>1]}, 32'h77);
  endtask

  // R9: section numbering
  task automatic t_sections();
    int exp_s [12] = '{0,0,1,1,1,1,2,2,2,2,2,3};
    fresh();
    put(enc(9,0,0,0,1)); put(enc(2,5,0,0,0));
    put(enc(9,0,0,0,2)); put(enc(9,0,0,0,3));
    put(enc(3,0,2,0,0)); put(enc(2,6,0,0,0));
    put(enc(0,0,0,0,0)); put(enc(9,0,0,0,4));
    put(enc(4,0,0,0,0)); put(enc(3,0,2,0,0));
    put(enc(2,5,0,0,0)); put(enc(0,0,0,0,0));
    start(20);
    for (int i = 0; i < 12; i++)
      expect_eq($sformatf("R9 section tag %0d", i), 32'(rsec[i]), 32'(exp_s[i]));
  endtask

  // R10: overflow at 16 entries, then R1 reset clears it
  task automatic t_overflow_reset();
    fresh();
    for (int i = 0; i < 17; i++) put(enc(9,0,0,0,i));
    start(40);
    expect_eq("R10 retired pushes", 32'(rc), 32'd16);
    expect_eq("R10 depth held full", {27'h0, stk_depth}, 32'd16);
    expect_eq("R10 overflow flag", {31'h0, ovf_fault}, 32'd1);
    expect_eq("R10 pc frozen", {24'h0, pc_o}, 32'd16);
    rst_n = 1'b0;
    @(negedge clk);
    expect_eq("R1 depth in reset", {27'h0, stk_depth}, 32'd0);
    expect_eq("R1 faults in reset", {30'h0, ovf_fault, unf_fault}, 32'd0);
    expect_eq("R1 pc in reset", {24'h0, pc_o}, 32'd0);
    expect_eq("R1 no retire/mem in reset", {29'h0, ret_valid, mem_re, mem_we}, 32'd0);
  endtask

  // R11: underflow cases
  task automatic t_underflow();
    fresh();
    put(enc(9,0,0,0,1)); put(enc(3,0,2,0,0)); put(enc(9,0,0,0,2));
    start(20);
    expect_eq("R11 two-entry op underflow", {31'h0, unf_fault}, 32'd1);
    expect_eq("R11 retired before fault", 32'(rc), 32'd1);
    expect_eq("R11 depth unchanged", {27'h0, stk_depth}, 32'd1);
    fresh();
    put(enc(2,3,0,0,0));
    start(10);
    expect_eq("R11 pop on empty", {31'h0, unf_fault}, 32'd1);
    expect_eq("R11 nothing retired", 32'(rc), 32'd0);
  endtask

  initial begin
    cyc = 0; nchk = 0; nerr = 0; rc = 0;
    t_overflow_reset();
    t_stack_alu();
    t_imm_reg();
    t_load();
    t_branch();
    t_sections();
    t_underflow();
    summary();
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    nchk = nchk + 1;
    nerr = nerr + 1;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    summary();
    $finish;
  end
endmodule